// File: doc/BRIEF.md
# Double-Buffered Prescaled PWM Channel

This block produces one pulse-width-modulated output with no software involvement once it is set up. A shared prescaler tick comes in from outside. A local programmable divider thins that tick stream, and each divided step advances a period counter. The counter is as wide as the `CNT_W` parameter (16 by default). Software writes a period length and a pulse width through a small register port. Both values land in shadow registers, and the running waveform picks them up only when a period wraps. This means a change in mid-period never produces a truncated or stretched pulse.

Each period starts with its active phase. The active phase lasts for the programmed width in counter steps, and the inactive phase fills the rest of the period. Software selects whether the active phase is high or low. A width of zero keeps the output inactive. A width of at least the period keeps it active for the whole period. The end of every period sets a sticky flag, and an enable bit lets that flag drive the interrupt line. When the channel is disabled, the pin follows a plain software data bit instead. The live pin level can always be read back.

Top module: `pwm_chan`

## Requirements
- R1: After reset `pin_out` is 0, `irq` is 0, and reading address 0 returns 0.
- R2: While the enable bit (address 0, bit 0) is 0, `pin_out` equals the data bit (address 0, bit 3), and ticks have no effect on it.
- R3: The period counter advances once every DIV+1 cycles in which `tick_in` is 1, where DIV is address 0, bits 15:8. With `tick_in` held at 0 it does not move.
- R4: For period P (address 1, P ≥ 1) and width W (address 2), the counter runs 0..P-1. The output is active while the count is below W and inactive for the rest of the period.
- R5: W = 0 keeps the output inactive for every cycle of every period.
- R6: W ≥ P keeps the output active for every cycle.
- R7: With the polarity bit (address 0, bit 1) at 1 the active level is high. With it at 0 the active level is low.
- R8: Writes to addresses 1 and 2 while running take effect only at the first step of the next period. The current period finishes with the old values.
- R9: A control write that changes the enable bit from 0 to 1 loads both shadow values at once and restarts the counter and the divider from zero. In the cycle after that write, the count is 0.
- R10: The step that wraps the counter sets the flag (address 0, bit 5). The flag stays set until a control write with bit 5 at 1 clears it. If a wrap and such a write coincide, the wrap wins.
- R11: `irq` is 1 exactly when the flag is set and the interrupt enable (address 0, bit 2) is 1.
- R12: Address 0, bit 4 reads back the current level of `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick_in | input | 1 | Shared prescaler tick, one cycle wide per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 period, 2 width |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address; address 3 reads 0 |
| rd_data | output | CNT_W | Read data, combinational from `rd_addr` |
| pin_out | output | 1 | Channel output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the programmed period is never zero while the channel runs. They also assume that `CNT_W` leaves room for the divider field. The bench only enables the channel after it has written a non-zero period. The assertions also assume a `tick_in` that is a plain level sampled each cycle. The bench holds it constant through each waveform run, either always high or always low, so the expected step times follow directly from the divider value. The bench makes every period and width change while the channel is disabled, with one exception: the deliberate mid-period width write that exercises the shadow registers.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // control register bit positions (address 0)
  localparam int B_EN   = 0;
  localparam int B_POL  = 1;
  localparam int B_IE   = 2;
  localparam int B_DOUT = 3;
  localparam int B_STAT = 4;
  localparam int B_FLAG = 5;
  localparam int B_DIV  = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_PER  = 2'd1,
    A_WID  = 2'd2,
    A_RSV  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] pc;

  function automatic logic at_terminal(input logic [PRE_W-1:0] c,
                                       input logic [PRE_W-1:0] d);
    return c == d;
  endfunction

  assign step = run && tick && at_terminal(pc, div);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pc <= '0;
    else if (tick)      pc <= at_terminal(pc, div) ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_wid,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] act_wid,
  output logic             wrap,
  output logic             active
);
  function automatic logic period_done(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] p);
    return (p == '0) || (c >= p - 1'b1);
  endfunction

  function automatic logic duty_on(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] w);
    return (w != '0) && (c < w);
  endfunction

  assign wrap   = step && period_done(cnt, act_per);
  assign active = duty_on(cnt, act_wid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_per <= '0;
      act_wid <= '0;
    end else if (restart || wrap) begin
      cnt     <= '0;
      act_per <= sh_per;
      act_wid <= sh_wid;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pin_out,
  output logic             irq
);
  import pwm_pkg::*;

  localparam int DIV_HI = B_DIV + PRE_W - 1;

  logic             en_q, pol_q, ie_q, dout_q, flag_q;
  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] sh_per, sh_wid;
  logic [CNT_W-1:0] cnt, act_per, act_wid;
  logic             step, wrap, active;

  // named events for the checker
  logic wr_ctrl, restart, wr_clr;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign restart = wr_ctrl && wr_data[B_EN] && !en_q;
  assign wr_clr  = wr_ctrl && wr_data[B_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      ie_q   <= 1'b0;
      dout_q <= 1'b0;
      div_q  <= '0;
      sh_per <= '0;
      sh_wid <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en_q   <= wr_data[B_EN];
          pol_q  <= wr_data[B_POL];
          ie_q   <= wr_data[B_IE];
          dout_q <= wr_data[B_DOUT];
          div_q  <= wr_data[DIV_HI:B_DIV];
        end
        A_PER:   sh_per <= wr_data;
        A_WID:   sh_wid <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (wrap)   flag_q <= 1'b1;
    else if (wr_clr) flag_q <= 1'b0;
  end

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q),
    .tick (tick_in),
    .div  (div_q),
    .step (step)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .step   (step),
    .sh_per (sh_per),
    .sh_wid (sh_wid),
    .cnt    (cnt),
    .act_per(act_per),
    .act_wid(act_wid),
    .wrap   (wrap),
    .active (active)
  );

  assign pin_out = en_q ? (pol_q ? active : !active) : dout_q;
  assign irq     = flag_q && ie_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_EN]          = en_q;
        rd_data[B_POL]         = pol_q;
        rd_data[B_IE]          = ie_q;
        rd_data[B_DOUT]        = dout_q;
        rd_data[B_STAT]        = pin_out;
        rd_data[B_FLAG]        = flag_q;
        rd_data[DIV_HI:B_DIV]  = div_q;
      end
      A_PER:   rd_data = sh_per;
      A_WID:   rd_data = sh_wid;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pol,
  input logic             ie,
  input logic             step,
  input logic             restart,
  input logic             wrap,
  input logic             wr_clr,
  input logic             flag,
  input logic             irq,
  input logic             pin,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_wid,
  input logic [1:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data
);
  // R3: the count only moves on a divided step or a restart
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt));

  // R4: count stays inside the active period
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_per != '0) |-> (cnt < act_per));

  // R5: zero width gives the inactive level
  a_r5_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_wid == '0) |-> (pin == !pol));

  // R6: width at or above the period gives the active level
  a_r6_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_per != '0 && act_wid >= act_per) |-> (pin == pol));

  // R8: active values change only at a wrap or a restart
  a_r8_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !restart) |=> ($stable(act_per) && $stable(act_wid)));

  // R9: the cycle after a restart starts at count zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R10: a wrap sets the flag, which then holds until cleared
  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_clr) |=> flag);

  // R11: no request while the interrupt is masked
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  // R12: status bit mirrors the pin
  a_r12_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[4] == pin));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en_q),
  .pol    (pol_q),
  .ie     (ie_q),
  .step   (step),
  .restart(restart),
  .wrap   (wrap),
  .wr_clr (wr_clr),
  .flag   (flag_q),
  .irq    (irq),
  .pin    (pin_out),
  .cnt    (cnt),
  .act_per(act_per),
  .act_wid(act_wid),
  .rd_addr(rd_addr),
  .rd_data(rd_data)
);

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_in = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic         pin_out, irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  pwm_chan uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_out(pin_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected pin levels as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (pin_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: cycle %0d pin_out=%b expected %b", it.tag, cyc, pin_out, it.exp);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ctrl(input bit en, input bit pol, input bit ie,
                                        input bit dout, input bit clr, input int div);
    logic [W-1:0] v;
    v = '0;
    v[0] = en; v[1] = pol; v[2] = ie; v[3] = dout; v[5] = clr;
    v[15:8] = div[7:0];
    return v;
  endfunction

  // starts at a negedge, ends at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic level(input int k, input int per, input int wid,
                                 input int div, input bit pol, input bit tk);
    int c;
    logic a;
    c = tk ? (k / (div + 1)) % per : 0;
    a = (wid != 0) && (c < wid);
    return pol ? a : !a;
  endfunction

  // driver: program shadows, queue the expected waveform, enable, run, disable
  task automatic run_wave(input int per, input int wid, input int div, input bit pol,
                          input bit tk, input int n, input string tag, input bit stat);
    item_t it;
    int c;
    wr(2'd1, W'(per));
    wr(2'd2, W'(wid));
    tick_in = tk;
    c = cyc;
    for (int k = 0; k < n; k++) begin
      it.due = c + 1 + k;
      it.exp = level(k, per, wid, div, pol, tk);
      it.tag = tag;
      sb.push_back(it);
    end
    wr(2'd0, ctrl(1, pol, 0, 0, 0, div));
    rd_addr = 2'd0;
    for (int k = 1; k < n; k++) begin
      if (stat) check("R12 status bit", int'(rd_data[4]), int'(pin_out));
      @(negedge clk);
    end
    wr(2'd0, ctrl(0, pol, 0, 0, 1, div));
    tick_in = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", int'(pin_out), 0);
    check("R1 irq", int'(irq), 0);
    rd_addr = 2'd0;
    check("R1 ctrl read", int'(rd_data), 0);

    // R2 fallback data bit, ticks ignored
    tick_in = 1'b1;
    wr(2'd0, ctrl(0, 1, 0, 1, 0, 0));
    repeat (4) @(negedge clk);
    check("R2 dout=1", int'(pin_out), 1);
    wr(2'd0, ctrl(0, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R2 dout=0", int'(pin_out), 0);

    // R4 / R7 / R12 basic waveform, active high
    run_wave(5, 2, 0, 1, 1, 20, "R4 per5 wid2", 1);
    // R7 inverted polarity
    run_wave(5, 2, 0, 0, 1, 15, "R7 active low", 0);
    // R5 zero width
    run_wave(4, 0, 0, 1, 1, 12, "R5 zero width", 0);
    // R6 width equal to and above period
    run_wave(3, 3, 0, 1, 1, 9,  "R6 width=period", 0);
    run_wave(3, 9, 0, 0, 1, 9,  "R6 width>period", 0);
    // R3 divider
    run_wave(3, 1, 2, 1, 1, 27, "R3 divide by 3", 0);
    run_wave(4, 2, 1, 1, 1, 16, "R3 divide by 2", 0);
    // R3 no ticks, counter frozen
    run_wave(4, 1, 0, 0, 0, 10, "R3 no tick", 0);
    // R9 restart after running part way with other values
    run_wave(6, 2, 0, 1, 1, 4,  "R9 first run", 0);
    run_wave(6, 4, 0, 1, 1, 12, "R9 restart loads new", 0);

    // R8 mid-period width change
    begin
      item_t it;
      int c;
      wr(2'd1, W'(4));
      wr(2'd2, W'(1));
      tick_in = 1'b1;
      c = cyc;
      for (int k = 0; k < 12; k++) begin
        it.due = c + 1 + k;
        it.exp = (k < 4) ? ((k % 4) < 1) : ((k % 4) < 3);
        it.tag = "R8 shadow width";
        sb.push_back(it);
      end
      wr(2'd0, ctrl(1, 1, 0, 0, 0, 0));
      wr(2'd2, W'(3));
      repeat (11) @(negedge clk);
      wr(2'd0, ctrl(0, 1, 0, 0, 1, 0));
    end

    // R10 / R11 flag timing with period 8
    wr(2'd1, W'(8));
    wr(2'd2, W'(3));
    wr(2'd0, ctrl(1, 1, 1, 0, 0, 0));
    rd_addr = 2'd0;
    repeat (7) @(negedge clk);
    check("R10 flag before wrap", int'(rd_data[5]), 0);
    check("R11 irq before wrap", int'(irq), 0);
    @(negedge clk);
    check("R10 flag at wrap", int'(rd_data[5]), 1);
    check("R11 irq at wrap", int'(irq), 1);
    wr(2'd0, ctrl(1, 1, 1, 0, 0, 0));
    check("R10 sticky", int'(rd_data[5]), 1);
    wr(2'd0, ctrl(1, 1, 1, 0, 1, 0));
    check("R10 cleared", int'(rd_data[5]), 0);
    check("R11 irq cleared", int'(irq), 0);
    wr(2'd0, ctrl(1, 1, 0, 0, 0, 0));
    repeat (8) @(negedge clk);
    check("R10 set again", int'(rd_data[5]), 1);
    check("R11 masked", int'(irq), 0);
    wr(2'd0, ctrl(0, 1, 1, 0, 0, 0));
    check("R11 unmasked", int'(irq), 1);
    check("R2 back to data bit", int'(pin_out), 0);
    wr(2'd0, ctrl(0, 1, 1, 0, 1, 0));
    check("R11 irq low after clear", int'(irq), 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule